// File: doc/BRIEF.md
# Grouped three-channel PWM counter timer

This block holds three 16-bit up-counters. Each counter has two compare values, A and B, and a control field. Software can tie any subset of the channels into a group. A write to the counter of any grouped channel loads the same value into every grouped counter. A compare-match clear raised by one grouped channel can reset the other grouped channels that are set to follow it. With these two features, one channel's compare-B value can set a shared period, and each channel's compare-A value sets where its edge falls inside that period. The three outputs then form phase-aligned PWM waveforms.

All state is reached through a small register bus. The bus has a one-cycle write strobe and a combinational read. Each channel owns four words at word address `ch*4`:

| Offset | Contents |
|---|---|
| +0 | counter |
| +1 | compare A |
| +2 | compare B |
| +3 | control: bits [2:0] clear select, bit 3 PWM enable |

Address 12 holds the run bits, bit n for channel n. Address 13 holds the group bits in the same layout. A single `count_en` input is the shared count-enable tick.

Top module: `sync_pwm_timer`

## Requirements
- R1: After reset, every register reads 0, all counters read 0 and all outputs are low.
- R2: A counter advances by one on each clock edge where both its run bit and `count_en` are 1, and it holds otherwise. With no clear, it wraps from 0xFFFF to 0.
- R3: Clear select 001 clears the counter on the edge after it equals compare A. Clear select 010 does the same with compare B. The counter therefore runs 0 up to the compare value.
- R4: Clear-select codes 000 and 1xx never clear the counter.
- R5: A bus write to the counter of a channel whose group bit is 1 loads that value, on the same edge, into every channel whose group bit is 1.
- R6: A bus write to the counter of a channel whose group bit is 0 loads only that counter. Counters of other channels are not changed.
- R7: A channel with group bit 1 and clear select 011 clears on any edge where a grouped channel clears through its own select 001 or 010.
- R8: A channel whose group bit is 0 ignores the group clear, even when its clear select is 011.
- R9: A bus write to a counter takes priority over counting and clearing on the same edge.
- R10: With PWM enable set, the output goes high on the edge after a compare-A match and low on the edge after a compare-B match. When both match in the same cycle, low wins. With PWM enable clear, the output is low.
- R11: Registers read back what was written, limited to their implemented bits. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Shared count-enable tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_out | output | 3 | PWM output, one bit per channel |

## Verification
The cycle where software writes a counter can be the same cycle where that counter meets its clear compare value. The bench provokes this by first loading the counter to one below compare B. It lets one edge pass, then writes a new value on the next edge, when the counter sits on the match. The read-back must show the written value, not zero. The second collision is compare A and compare B set equal, so both PWM actions fall on one edge. The bench checks that the output stays low through the match.

// File: rtl/sptmr_pkg.sv
package sptmr_pkg;

    typedef enum logic [2:0] {
        CLR_NONE = 3'b000,
        CLR_ON_A = 3'b001,
        CLR_ON_B = 3'b010,
        CLR_SYNC = 3'b011
    } clr_sel_e;

    localparam int unsigned REGS_PER_CH = 4;
    localparam int unsigned OFS_CNT     = 0;
    localparam int unsigned OFS_CMPA    = 1;
    localparam int unsigned OFS_CMPB    = 2;
    localparam int unsigned OFS_CTRL    = 3;
    localparam int unsigned CTRL_W      = 4;

    typedef struct packed {
        logic       pwm_en;
        logic [2:0] clr_sel;
    } ch_ctrl_t;

endpackage

// File: rtl/sptmr_regs.sv
module sptmr_regs
    import sptmr_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [CNT_W-1:0]                wdata,
    output logic [N_CH-1:0][CNT_W-1:0]      cmpa,
    output logic [N_CH-1:0][CNT_W-1:0]      cmpb,
    output ch_ctrl_t [N_CH-1:0]             ctrl,
    output logic [N_CH-1:0]                 run_en,
    output logic [N_CH-1:0]                 grp_en,
    output logic [N_CH-1:0]                 cnt_load
);

    localparam int unsigned RUN_ADDR = N_CH * REGS_PER_CH;
    localparam int unsigned GRP_ADDR = RUN_ADDR + 1;

    typedef struct packed {
        logic [N_CH-1:0][CNT_W-1:0] cmpa;
        logic [N_CH-1:0][CNT_W-1:0] cmpb;
        ch_ctrl_t [N_CH-1:0]        ctrl;
        logic [N_CH-1:0]            run;
        logic [N_CH-1:0]            grp;
    } regs_t;

    regs_t           r_d, r_q;
    logic [N_CH-1:0] cnt_hit;
    logic            grp_hit;

    always_comb begin
        r_d     = r_q;
        cnt_hit = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (wr_en && addr == ADDR_W'(ch * REGS_PER_CH + OFS_CNT))
                cnt_hit[ch] = 1'b1;
            if (wr_en && addr == ADDR_W'(ch * REGS_PER_CH + OFS_CMPA))
                r_d.cmpa[ch] = wdata;
            if (wr_en && addr == ADDR_W'(ch * REGS_PER_CH + OFS_CMPB))
                r_d.cmpb[ch] = wdata;
            if (wr_en && addr == ADDR_W'(ch * REGS_PER_CH + OFS_CTRL))
                r_d.ctrl[ch] = ch_ctrl_t'(wdata[CTRL_W-1:0]);
        end
        if (wr_en && addr == ADDR_W'(RUN_ADDR))
            r_d.run = wdata[N_CH-1:0];
        if (wr_en && addr == ADDR_W'(GRP_ADDR))
            r_d.grp = wdata[N_CH-1:0];
        grp_hit  = |(cnt_hit & r_q.grp);
        cnt_load = cnt_hit | (r_q.grp & {N_CH{grp_hit}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmpa   = r_q.cmpa;
    assign cmpb   = r_q.cmpb;
    assign ctrl   = r_q.ctrl;
    assign run_en = r_q.run;
    assign grp_en = r_q.grp;

endmodule

// File: rtl/sptmr_chan.sv
module sptmr_chan
    import sptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    input  ch_ctrl_t         ctrl,
    input  logic             grp_en,
    input  logic             grp_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             own_clr,
    output logic             pwm
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pwm;
    } chan_t;

    chan_t s_d, s_q;
    logic  match_a, match_b, follow_clr;

    always_comb begin
        match_a    = (s_q.cnt == cmpa);
        match_b    = (s_q.cnt == cmpb);
        own_clr    = tick && (((ctrl.clr_sel == CLR_ON_A) && match_a) ||
                              ((ctrl.clr_sel == CLR_ON_B) && match_b));
        follow_clr = tick && grp_en && (ctrl.clr_sel == CLR_SYNC) && grp_clr;

        s_d = s_q;
        if (load)
            s_d.cnt = load_val;
        else if (tick)
            s_d.cnt = (own_clr || follow_clr) ? '0 : s_q.cnt + 1'b1;

        if (!ctrl.pwm_en)
            s_d.pwm = 1'b0;
        else if (tick && match_b)
            s_d.pwm = 1'b0;
        else if (tick && match_a)
            s_d.pwm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign pwm = s_q.pwm;

endmodule

// File: rtl/sptmr_grpclr.sv
module sptmr_grpclr #(
    parameter int N_CH = 3
) (
    input  logic [N_CH-1:0] own_clr,
    input  logic [N_CH-1:0] grp_en,
    output logic            grp_clr
);

    always_comb begin
        grp_clr = |(own_clr & grp_en);
    end

endmodule

// File: rtl/sync_pwm_timer.sv
module sync_pwm_timer
    import sptmr_pkg::*;
#(
    parameter int N_CH  = 3,
    parameter int CNT_W = 16,
    localparam int ADDR_W = $clog2(N_CH * REGS_PER_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [N_CH-1:0]   pwm_out
);

    localparam int unsigned RUN_ADDR = N_CH * REGS_PER_CH;
    localparam int unsigned GRP_ADDR = RUN_ADDR + 1;

    logic [N_CH-1:0][CNT_W-1:0] cnt_vec;
    logic [N_CH-1:0][CNT_W-1:0] cmpa_vec;
    logic [N_CH-1:0][CNT_W-1:0] cmpb_vec;
    ch_ctrl_t [N_CH-1:0]        ctrl_vec;
    logic [N_CH-1:0]            run_vec;
    logic [N_CH-1:0]            grp_vec;
    logic [N_CH-1:0]            load_vec;
    logic [N_CH-1:0]            own_clr_vec;
    logic                       grp_clr;

    sptmr_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cmpa     (cmpa_vec),
        .cmpb     (cmpb_vec),
        .ctrl     (ctrl_vec),
        .run_en   (run_vec),
        .grp_en   (grp_vec),
        .cnt_load (load_vec)
    );

    sptmr_grpclr #(.N_CH(N_CH)) u_grpclr (
        .own_clr (own_clr_vec),
        .grp_en  (grp_vec),
        .grp_clr (grp_clr)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        sptmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (run_vec[g] & count_en),
            .load     (load_vec[g]),
            .load_val (wdata),
            .cmpa     (cmpa_vec[g]),
            .cmpb     (cmpb_vec[g]),
            .ctrl     (ctrl_vec[g]),
            .grp_en   (grp_vec[g]),
            .grp_clr  (grp_clr),
            .cnt      (cnt_vec[g]),
            .own_clr  (own_clr_vec[g]),
            .pwm      (pwm_out[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (addr == ADDR_W'(ch * REGS_PER_CH + OFS_CNT))  rdata = cnt_vec[ch];
            if (addr == ADDR_W'(ch * REGS_PER_CH + OFS_CMPA)) rdata = cmpa_vec[ch];
            if (addr == ADDR_W'(ch * REGS_PER_CH + OFS_CMPB)) rdata = cmpb_vec[ch];
            if (addr == ADDR_W'(ch * REGS_PER_CH + OFS_CTRL))
                rdata = CNT_W'(ctrl_vec[ch]);
        end
        if (addr == ADDR_W'(RUN_ADDR)) rdata = CNT_W'(run_vec);
        if (addr == ADDR_W'(GRP_ADDR)) rdata = CNT_W'(grp_vec);
    end

endmodule

// File: rtl/sptmr_chk.sv
module sptmr_chk
    import sptmr_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       count_en,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [CNT_W-1:0]           wdata,
    input logic [N_CH-1:0]            pwm_out,
    input logic [N_CH-1:0][CNT_W-1:0] cnt_vec,
    input logic [N_CH-1:0][CNT_W-1:0] cmpa_vec,
    input logic [N_CH-1:0][CNT_W-1:0] cmpb_vec,
    input ch_ctrl_t [N_CH-1:0]        ctrl_vec,
    input logic [N_CH-1:0]            run_vec,
    input logic [N_CH-1:0]            grp_vec
);

    logic [N_CH-1:0] hit, tk;
    logic            grp_write;

    always_comb begin
        for (int ch = 0; ch < N_CH; ch++) begin
            hit[ch] = wr_en && (addr == ADDR_W'(ch * REGS_PER_CH));
            tk[ch]  = run_vec[ch] && count_en;
        end
        grp_write = |(hit & grp_vec);
    end

    for (genvar j = 0; j < N_CH; j++) begin : g_chk
        // R5
        grp_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_write && grp_vec[j]) |=> (cnt_vec[j] == $past(wdata)));

        // R9
        write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[j] |=> (cnt_vec[j] == $past(wdata)));

        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tk[j] && !(grp_write && grp_vec[j]) && !hit[j]) |=> $stable(cnt_vec[j]));

        // R3
        clear_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tk[j] && !hit[j] && !(grp_write && grp_vec[j]) &&
             ctrl_vec[j].clr_sel == CLR_ON_A && cnt_vec[j] == cmpa_vec[j])
            |=> (cnt_vec[j] == '0));

        // R10
        low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tk[j] && ctrl_vec[j].pwm_en && cnt_vec[j] == cmpb_vec[j]) |=> !pwm_out[j]);
    end

endmodule

bind sync_pwm_timer sptmr_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .pwm_out  (pwm_out),
    .cnt_vec  (cnt_vec),
    .cmpa_vec (cmpa_vec),
    .cmpb_vec (cmpb_vec),
    .ctrl_vec (ctrl_vec),
    .run_vec  (run_vec),
    .grp_vec  (grp_vec)
);

// File: tb/test_sync_pwm_timer.sv
module test_sync_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [2:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sync_pwm_timer i_sync_pwm_timer (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%h expected=0x%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0; count_en = 1'b1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called at a falling edge; ends at a falling edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            check("R1 reset register", v, 16'h0000);
        end
        check("R1 reset outputs", {13'd0, pwm_out}, 16'h0000);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        do_reset();
        wr(4'd5, 16'hBEEF);  rd(4'd5, v);  check("R11 compare A ch1", v, 16'hBEEF);
        wr(4'd10, 16'h1357); rd(4'd10, v); check("R11 compare B ch2", v, 16'h1357);
        wr(4'd11, 16'hFFFF); rd(4'd11, v); check("R11 control width", v, 16'h000F);
        wr(4'd12, 16'hFFF8); rd(4'd12, v); check("R11 run width", v, 16'h0000);
        wr(4'd13, 16'hFFF5); rd(4'd13, v); check("R11 group width", v, 16'h0005);
        wr(4'd14, 16'hFFFF); rd(4'd14, v); check("R11 unused address", v, 16'h0000);
    endtask

    task automatic t_count();
        logic [15:0] v;
        do_reset();
        wr(4'd0, 16'hFFFD);
        edges(2);
        rd(4'd0, v); check("R2 stopped holds", v, 16'hFFFD);
        wr(4'd12, 16'h0001);
        rd(4'd0, v); check("R2 no count on run write edge", v, 16'hFFFD);
        edges(3);
        rd(4'd0, v); check("R2 wrap to zero", v, 16'h0000);
        count_en = 1'b0;
        edges(3);
        rd(4'd0, v); check("R2 count enable low holds", v, 16'h0000);
        count_en = 1'b1;
        edges(2);
        rd(4'd0, v); check("R2 resumes", v, 16'h0002);
    endtask

    task automatic t_own_clear();
        logic [15:0] v;
        do_reset();
        wr(4'd2, 16'd4);  wr(4'd3, 16'h0002);   // ch0 clear on B
        wr(4'd5, 16'd2);  wr(4'd7, 16'h0001);   // ch1 clear on A
        wr(4'd9, 16'd2);  wr(4'd10, 16'd2); wr(4'd11, 16'h0004); // ch2 reserved
        wr(4'd12, 16'h0007);
        edges(4);
        rd(4'd0, v); check("R3 reaches compare B", v, 16'd4);
        rd(4'd4, v); check("R3 clear on A period", v, 16'd1);
        rd(4'd8, v); check("R4 reserved code keeps counting", v, 16'd4);
        edges(1);
        rd(4'd0, v); check("R3 clear after B match", v, 16'd0);
        rd(4'd4, v); check("R3 clear on A second pass", v, 16'd2);
        rd(4'd8, v); check("R4 reserved code no clear", v, 16'd5);
    endtask

    task automatic t_group_preset();
        logic [15:0] v;
        do_reset();
        wr(4'd2, 16'h1236); wr(4'd3, 16'h0002);  // ch0 clears on B
        wr(4'd11, 16'h0003);                      // ch2 follower, not grouped
        wr(4'd13, 16'h0003);                      // group ch0 and ch1
        wr(4'd8, 16'h0050);
        wr(4'd4, 16'h1234);
        rd(4'd0, v); check("R5 preset reaches ch0", v, 16'h1234);
        rd(4'd4, v); check("R5 preset written ch1", v, 16'h1234);
        rd(4'd8, v); check("R6 ungrouped ch2 untouched", v, 16'h0050);
        wr(4'd8, 16'h0077);
        rd(4'd0, v); check("R6 ungrouped write stays local", v, 16'h1234);
        rd(4'd8, v); check("R6 ungrouped write loads ch2", v, 16'h0077);
        wr(4'd12, 16'h0005);
        edges(3);
        rd(4'd0, v); check("R3 grouped leader clears", v, 16'h0000);
        rd(4'd8, v); check("R8 ungrouped follower ignores group clear", v, 16'h007A);
        rd(4'd4, v); check("R2 stopped grouped ch1 holds", v, 16'h1234);
    endtask

    task automatic t_three_phase();
        logic [15:0] v;
        logic [2:0]  exp;
        int          p;
        int          a [3];
        a[0] = 2; a[1] = 4; a[2] = 6;
        do_reset();
        wr(4'd13, 16'h0007);
        wr(4'd1, 16'd2); wr(4'd2, 16'd9); wr(4'd3, 16'h000A);
        wr(4'd5, 16'd4); wr(4'd6, 16'd9); wr(4'd7, 16'h000B);
        wr(4'd9, 16'd6); wr(4'd10, 16'd9); wr(4'd11, 16'h000B);
        wr(4'd4, 16'h0000);
        wr(4'd12, 16'h0007);
        for (int k = 1; k <= 25; k++) begin
            edges(1);
            p = (k - 1) % 10;
            for (int c = 0; c < 3; c++) exp[c] = (p >= a[c]) && (p <= 8);
            check("R10 three-phase outputs", {13'd0, pwm_out}, {13'd0, exp});
            if (k % 5 == 0) begin
                for (int c = 0; c < 3; c++) begin
                    rd(4'(c * 4), v);
                    check("R7 grouped counters follow leader period", v, 16'(k % 10));
                end
            end
        end
    endtask

    task automatic t_priority();
        logic [15:0] v;
        do_reset();
        wr(4'd2, 16'd4); wr(4'd3, 16'h0002);
        wr(4'd12, 16'h0001);
        wr(4'd0, 16'd3);
        edges(1);
        rd(4'd0, v); check("R9 counter at match", v, 16'd4);
        wr(4'd0, 16'h0100);
        rd(4'd0, v); check("R9 write beats clear", v, 16'h0100);
        wr(4'd9, 16'd5); wr(4'd10, 16'd5); wr(4'd11, 16'h0008);
        wr(4'd5, 16'd0); wr(4'd7, 16'h0000);
        wr(4'd8, 16'd3);
        wr(4'd12, 16'h0007);
        edges(6);
        check("R10 equal compares keep output low", {15'd0, pwm_out[2]}, 16'd0);
        check("R10 disabled PWM stays low", {15'd0, pwm_out[1]}, 16'd0);
        rd(4'd8, v); check("R4 code 000 passes compare", v, 16'd9);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_count();
        t_own_clear();
        t_group_preset();
        t_three_phase();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule